// File: doc/BRIEF.md
# Add and Compare Flag Unit

This unit is the arithmetic and status-flag stage of an 8-bit processor core. It supports five operations: a byte add that takes a carry in, a word add on the 16-bit pair made from the Y and A registers, byte and word compares, and a register move that only updates the flags. For each operation it produces the result and the new N, V, H, Z and C flags. Any flag the operation does not define is copied from the flag vector supplied with the request.

The surrounding sequencer fetches the operands and puts the accumulator (or the YA pair) on `opa` and the memory operand on `opb`. It then raises `op_valid` for one cycle. One clock later the registered result and flags are presented, with `res_valid` high. For a word add, the upper result byte goes back to Y and the lower byte goes back to A. A compare leaves the result register unchanged.

Top module: `addcmp_flag_unit`

## Requirements
- R1: While `rst_n` is low, `res`, `flags_out` and `res_valid` are all zero.
- R2: An operation accepted while `op_valid` is high appears on `res` and `flags_out` on the next rising edge, and `res_valid` is high for that one cycle. While `op_valid` is low, `res` and `flags_out` hold their values and `res_valid` is low.
- R3: Byte add (`op_sel` = 0) gives `res[7:0]` = `opa[7:0]` + `opb[7:0]` + `cin` modulo 256, with `res[15:8]` = 0. C is set to the carry out of bit 7, and the upper operand bytes have no effect.
- R4: For the byte add, H is set when `opa[3:0]` + `opb[3:0]` + `cin` is 16 or more. V is set when both operands have the same sign and the 8-bit result has the opposite sign.
- R5: On every flag-writing operation, N equals the top bit of the result (bit 7 for byte operations, bit 15 for word operations), and Z is set exactly when that result is zero.
- R6: Word add (`op_sel` = 1) gives `res` = `opa` + `opb` modulo 65536, and `cin` is ignored. C is the carry out of bit 15, V is signed 16-bit overflow, and H is set when `opa[11:0]` + `opb[11:0]` is 0x1000 or more. `res[15:8]` is the new Y and `res[7:0]` is the new A.
- R7: Byte compare (`op_sel` = 2) computes `opa[7:0]` − `opb[7:0]`. It sets C when `opa[7:0]` ≥ `opb[7:0]` as unsigned values, and sets N and Z from the 8-bit difference. V and H are copied from `flags_in`, and `res` is left unchanged.
- R8: Word compare (`op_sel` = 3) does the same as R7 on all 16 bits. C is set when the difference extended to 17 bits is 0x10000 or more.
- R9: Move (`op_sel` = 4) gives `res` = {8'h00, `opa[7:0]`} and writes only N and Z. V, H and C are copied from `flags_in`.
- R10: Flag vectors are packed as {N, V, H, Z, C} in bits 4 down to 0. An `op_sel` value of 5, 6 or 7 leaves `res` unchanged and sets `flags_out` equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept an operation this cycle |
| op_sel | input | 3 | Operation code |
| opa | input | 16 | First operand (accumulator or YA pair) |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry in, used only by the byte add |
| flags_in | input | 5 | Current flags {N,V,H,Z,C} |
| res | output | 16 | Registered result |
| flags_out | output | 5 | Registered updated flags {N,V,H,Z,C} |
| res_valid | output | 1 | Result and flags were updated on the last edge |

## Verification
The properties assume that `op_valid`, `op_sel`, the operands and `flags_in` change only between edges. They also assume these inputs are held low during reset, so that every `$past` sample is a defined value captured after reset. The bench drives all inputs on the falling edge and holds `op_valid` low throughout reset. It reaches the undefined op codes only through a deliberate vector, and the properties on those codes expect no result change.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;

   typedef enum logic [2:0] {
      OP_ADC8 = 3'd0,
      OP_ADDW = 3'd1,
      OP_CMP8 = 3'd2,
      OP_CMPW = 3'd3,
      OP_MOV  = 3'd4
   } op_e;

   typedef struct packed {
      logic n;
      logic v;
      logic h;
      logic z;
      logic c;
   } flags_t;

   localparam int FLAG_W = 5;

endpackage

// File: rtl/fu_adder.sv
module fu_adder #(
   parameter int W        = 8,
   parameter int HALF_BIT = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         half,
   output logic         ovf
);

   if (HALF_BIT < 1 || HALF_BIT >= W) begin : g_bad_half
      $error("fu_adder: HALF_BIT must lie inside the operand width");
   end

   logic [W:0]        full;
   logic [HALF_BIT:0] low;

   assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
   assign low  = {1'b0, a[HALF_BIT-1:0]} + {1'b0, b[HALF_BIT-1:0]}
               + {{HALF_BIT{1'b0}}, cin};

   assign sum  = full[W-1:0];
   assign cout = full[W];
   assign half = low[HALF_BIT];
   assign ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/fu_flag_select.sv
module fu_flag_select
   import addcmp_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic [2:0]        op_sel,
   input  flags_t            flags_in,
   input  logic [BYTE_W-1:0] mov_src,
   input  logic [BYTE_W-1:0] b_sum,
   input  logic              b_cout,
   input  logic              b_half,
   input  logic              b_ovf,
   input  logic [WORD_W-1:0] w_sum,
   input  logic              w_cout,
   input  logic              w_half,
   input  logic              w_ovf,
   output logic [WORD_W-1:0] nxt_res,
   output flags_t            nxt_flags,
   output logic              wr_res
);

   always_comb begin
      nxt_res   = '0;
      nxt_flags = flags_in;
      wr_res    = 1'b0;
      case (op_sel)
         OP_ADC8: begin
            nxt_res     = {{BYTE_W{1'b0}}, b_sum};
            wr_res      = 1'b1;
            nxt_flags.n = b_sum[BYTE_W-1];
            nxt_flags.v = b_ovf;
            nxt_flags.h = b_half;
            nxt_flags.z = ~|b_sum;
            nxt_flags.c = b_cout;
         end
         OP_ADDW: begin
            nxt_res     = w_sum;
            wr_res      = 1'b1;
            nxt_flags.n = w_sum[WORD_W-1];
            nxt_flags.v = w_ovf;
            nxt_flags.h = w_half;
            nxt_flags.z = ~|w_sum;
            nxt_flags.c = w_cout;
         end
         OP_CMP8: begin
            nxt_flags.n = b_sum[BYTE_W-1];
            nxt_flags.z = ~|b_sum;
            nxt_flags.c = b_cout;
         end
         OP_CMPW: begin
            nxt_flags.n = w_sum[WORD_W-1];
            nxt_flags.z = ~|w_sum;
            nxt_flags.c = w_cout;
         end
         OP_MOV: begin
            nxt_res     = {{BYTE_W{1'b0}}, mov_src};
            wr_res      = 1'b1;
            nxt_flags.n = mov_src[BYTE_W-1];
            nxt_flags.z = ~|mov_src;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/addcmp_flag_unit.sv
module addcmp_flag_unit
   import addcmp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4,
   localparam int WORD_W    = 2 * BYTE_W,
   localparam int WORD_HALF = WORD_W - NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   input  logic              cin,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [WORD_W-1:0] res,
   output logic [FLAG_W-1:0] flags_out,
   output logic              res_valid
);

   if (NIB_W < 1 || NIB_W >= BYTE_W) begin : g_bad_nib
      $error("addcmp_flag_unit: NIB_W must be smaller than BYTE_W");
   end

   logic              is_cmp8, is_cmpw;
   logic [BYTE_W-1:0] b_opb, b_sum;
   logic [WORD_W-1:0] w_opb, w_sum;
   logic              b_cin, b_cout, b_half, b_ovf;
   logic              w_cout, w_half, w_ovf;
   logic [WORD_W-1:0] nxt_res;
   flags_t            nxt_flags;
   logic              wr_res;

   assign is_cmp8 = (op_sel == OP_CMP8);
   assign is_cmpw = (op_sel == OP_CMPW);

   // subtraction is an add of the inverted operand with a forced carry
   assign b_opb = is_cmp8 ? ~opb[BYTE_W-1:0] : opb[BYTE_W-1:0];
   assign b_cin = is_cmp8 ? 1'b1 : cin;
   assign w_opb = is_cmpw ? ~opb : opb;

   fu_adder #(.W(BYTE_W), .HALF_BIT(NIB_W)) u_byte_add (
      .a    (opa[BYTE_W-1:0]),
      .b    (b_opb),
      .cin  (b_cin),
      .sum  (b_sum),
      .cout (b_cout),
      .half (b_half),
      .ovf  (b_ovf)
   );

   fu_adder #(.W(WORD_W), .HALF_BIT(WORD_HALF)) u_word_add (
      .a    (opa),
      .b    (w_opb),
      .cin  (is_cmpw),
      .sum  (w_sum),
      .cout (w_cout),
      .half (w_half),
      .ovf  (w_ovf)
   );

   fu_flag_select #(.BYTE_W(BYTE_W)) u_sel (
      .op_sel    (op_sel),
      .flags_in  (flags_t'(flags_in)),
      .mov_src   (opa[BYTE_W-1:0]),
      .b_sum     (b_sum),
      .b_cout    (b_cout),
      .b_half    (b_half),
      .b_ovf     (b_ovf),
      .w_sum     (w_sum),
      .w_cout    (w_cout),
      .w_half    (w_half),
      .w_ovf     (w_ovf),
      .nxt_res   (nxt_res),
      .nxt_flags (nxt_flags),
      .wr_res    (wr_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res       <= '0;
         flags_out <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= op_valid;
         if (op_valid) begin
            flags_out <= nxt_flags;
            if (wr_res) res <= nxt_res;
         end
      end
   end

endmodule

// File: rtl/addcmp_flag_unit_chk.sv
module addcmp_flag_unit_chk
   import addcmp_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int WORD_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [2:0]        op_sel,
   input logic [WORD_W-1:0] opa,
   input logic [WORD_W-1:0] opb,
   input logic [FLAG_W-1:0] flags_in,
   input logic [WORD_W-1:0] res,
   input logic [FLAG_W-1:0] flags_out,
   input logic              res_valid
);

   // R1
   reset_zero_chk: assert property (@(posedge clk)
      !rst_n |-> (res == '0 && flags_out == '0 && !res_valid));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!res_valid && $stable(res) && $stable(flags_out)));

   // R6
   addw_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_ADDW) |=> res == WORD_W'($past(opa) + $past(opb)));

   // R5
   addw_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_ADDW) |=>
         (flags_out[1] == (res == '0) && flags_out[4] == res[WORD_W-1]));

   // R7
   cmp8_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_CMP8) |=>
         ($stable(res) && flags_out[3:2] == $past(flags_in[3:2])));

   // R8
   cmpw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_CMPW) |=>
         ($stable(res) && flags_out[3:2] == $past(flags_in[3:2])));

   // R9
   mov_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel == OP_MOV) |=>
         (res == {{BYTE_W{1'b0}}, $past(opa[BYTE_W-1:0])}
          && flags_out[3:0] == {$past(flags_in[3:2]), (res == '0), $past(flags_in[0])}));

   // R10
   undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_sel > 3'd4) |=> ($stable(res) && flags_out == $past(flags_in)));

endmodule

bind addcmp_flag_unit addcmp_flag_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_sel    (op_sel),
   .opa       (opa),
   .opb       (opb),
   .flags_in  (flags_in),
   .res       (res),
   .flags_out (flags_out),
   .res_valid (res_valid)
);

// File: tb/addcmp_flag_unit_test.sv
module addcmp_flag_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_sel = 3'd0;
   logic [15:0] opa = '0;
   logic [15:0] opb = '0;
   logic        cin = 1'b0;
   logic [4:0]  flags_in = '0;
   logic [15:0] res;
   logic [4:0]  flags_out;
   logic        res_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   addcmp_flag_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_sel    (op_sel),
      .opa       (opa),
      .opb       (opb),
      .cin       (cin),
      .flags_in  (flags_in),
      .res       (res),
      .flags_out (flags_out),
      .res_valid (res_valid)
   );

   // {op, opa, opb, cin, flags_in, expected res, expected flags {N,V,H,Z,C}}
   localparam int NV = 19;
   localparam logic [61:0] VEC [NV] = '{
      {3'd0, 16'h0012, 16'h0034, 1'b0, 5'h00, 16'h0046, 5'h00},
      {3'd0, 16'h000F, 16'h0001, 1'b0, 5'h00, 16'h0010, 5'h04},
      {3'd0, 16'h000F, 16'h0000, 1'b1, 5'h00, 16'h0010, 5'h04},
      {3'd0, 16'h007F, 16'h0000, 1'b1, 5'h00, 16'h0080, 5'h1C},
      {3'd0, 16'h00FF, 16'h0001, 1'b0, 5'h00, 16'h0000, 5'h07},
      {3'd0, 16'h0080, 16'h0080, 1'b0, 5'h00, 16'h0000, 5'h0B},
      {3'd1, 16'h0800, 16'h0800, 1'b1, 5'h00, 16'h1000, 5'h04},
      {3'd1, 16'h7FFF, 16'h0001, 1'b1, 5'h00, 16'h8000, 5'h1C},
      {3'd2, 16'h0040, 16'h0040, 1'b1, 5'h0C, 16'h8000, 5'h0F},
      {3'd2, 16'h0010, 16'h0020, 1'b0, 5'h00, 16'h8000, 5'h10},
      {3'd3, 16'h1234, 16'h1233, 1'b0, 5'h1F, 16'h8000, 5'h0D},
      {3'd3, 16'h0000, 16'h0001, 1'b0, 5'h00, 16'h8000, 5'h10},
      {3'd4, 16'hFF00, 16'h1234, 1'b0, 5'h0D, 16'h0000, 5'h0F},
      {3'd4, 16'h1280, 16'h0000, 1'b1, 5'h00, 16'h0080, 5'h10},
      {3'd5, 16'h1111, 16'h2222, 1'b1, 5'h15, 16'h0080, 5'h15},
      {3'd1, 16'hFFFF, 16'h0001, 1'b0, 5'h00, 16'h0000, 5'h07},
      {3'd1, 16'h8000, 16'h8000, 1'b0, 5'h00, 16'h0000, 5'h0B},
      {3'd0, 16'hAB01, 16'hCD01, 1'b0, 5'h00, 16'h0002, 5'h00},
      {3'd2, 16'h0105, 16'hFF05, 1'b0, 5'h00, 16'h0002, 5'h03}
   };

   function automatic string tag_of(logic [2:0] op);
      case (op)
         3'd0:    return "R3 R4 R5";
         3'd1:    return "R6 R5";
         3'd2:    return "R7";
         3'd3:    return "R8";
         3'd4:    return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [15:0] held_res;
      logic [4:0]  held_flags;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 res", res, 16'h0000);
      chk("R1 flags", {11'd0, flags_out}, 16'h0000);
      chk("R1 valid", {15'd0, res_valid}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         op_sel   = VEC[i][61:59];
         opa      = VEC[i][58:43];
         opb      = VEC[i][42:27];
         cin      = VEC[i][26];
         flags_in = VEC[i][25:21];
         op_valid = 1'b1;
         @(negedge clk);
         chk({tag_of(VEC[i][61:59]), " res"}, res, VEC[i][20:5]);
         chk({tag_of(VEC[i][61:59]), " flags"}, {11'd0, flags_out}, {11'd0, VEC[i][4:0]});
         chk("R2 valid", {15'd0, res_valid}, 16'h0001);
      end

      // R2: idle cycles hold the outputs while inputs move
      held_res   = res;
      held_flags = flags_out;
      op_valid   = 1'b0;
      op_sel     = 3'd1;
      opa        = 16'h4321;
      opb        = 16'h1111;
      flags_in   = 5'h1F;
      repeat (2) @(negedge clk);
      chk("R2 idle res", res, held_res);
      chk("R2 idle flags", {11'd0, flags_out}, {11'd0, held_flags});
      chk("R2 idle valid", {15'd0, res_valid}, 16'h0000);

      // R6: carry in has no effect on the word add
      op_valid = 1'b1;
      op_sel   = 3'd1;
      opa      = 16'h00FF;
      opb      = 16'h0001;
      cin      = 1'b1;
      flags_in = 5'h00;
      @(negedge clk);
      chk("R6 cin ignored res", res, 16'h0100);
      chk("R6 cin ignored flags", {11'd0, flags_out}, 16'h0000);

      // R3: carry in chains into the byte add
      op_sel = 3'd0;
      opa    = 16'h00FE;
      opb    = 16'h0001;
      cin    = 1'b1;
      @(negedge clk);
      chk("R3 carry chain res", res, 16'h0000);
      chk("R3 carry chain flags", {11'd0, flags_out}, 16'h0007);

      // R1: reset during operation clears everything
      op_valid = 1'b0;
      rst_n    = 1'b0;
      #2;
      chk("R1 midrun res", res, 16'h0000);
      chk("R1 midrun flags", {11'd0, flags_out}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release valid", {15'd0, res_valid}, 16'h0000);

      finish_run();
   end

endmodule